// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block takes two IEEE-754 binary floating-point operands (binary64 by default) and turns their relationship into a six-bit condition flag vector of the kind a processor status register holds. Each operand is sorted into one of four outcomes: first operand greater, first operand less, both equal, or unordered. The outcome is written onto the carry, parity and zero flags. The overflow, sign and auxiliary-carry flags are cleared on every write.

The block also detects two exceptions. An invalid-operation exception depends on the mode input. A signalling compare raises it for any NaN. A quiet compare raises it only for a signalling NaN. A denormal-operand exception is raised for any subnormal input. Each exception has a mask input. An exception that is raised while its mask is clear blocks the write, so the flag vector keeps its earlier contents. The exception status outputs pulse for one cycle whatever the masks hold. A request is one cycle of the valid strobe. All outputs are registered and respond on the clock edge that samples the strobe.

Top module: `cmpf_flag_unit`

## Requirements
- R1: For ordered operands, flags_o[2:0] (bit 2 zero, bit 1 parity, bit 0 carry) become 000 when op_a_i > op_b_i, 001 when op_a_i < op_b_i, and 100 when they are equal.
- R2: When either operand is a NaN (all-ones exponent, nonzero fraction), flags_o[2:0] become 111.
- R3: flags_o[5:3] (bit 3 auxiliary carry, bit 4 sign, bit 5 overflow) are 0 after every write.
- R4: Negative zero and positive zero compare as equal.
- R5: With sig_mode_i = 1, inv_o pulses when either operand is any NaN.
- R6: With sig_mode_i = 0, inv_o pulses only when an operand is a signalling NaN, meaning the top fraction bit is 0.
- R7: den_o pulses when either operand is subnormal (zero exponent, nonzero fraction).
- R8: A mask input of 1 masks its exception. When a raised exception has its mask at 0, flags_o keeps its previous value.
- R9: Outputs respond one clock after the strobe. In a cycle after which valid_i was low, inv_o and den_o are 0 and flags_o is unchanged.
- R10: Subnormal operands are compared by their exact values and are not flushed to zero.
- R11: During and after reset, flags_o is 0 and inv_o and den_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Compare strobe |
| op_a_i | input | 1+EXP_W+MAN_W | First operand |
| op_b_i | input | 1+EXP_W+MAN_W | Second operand |
| sig_mode_i | input | 1 | 1 = signalling compare, 0 = quiet compare |
| inv_mask_i | input | 1 | 1 masks the invalid-operation exception |
| den_mask_i | input | 1 | 1 masks the denormal-operand exception |
| flags_o | output | 6 | Flag vector {ovf, sign, aux, zero, parity, carry} |
| inv_o | output | 1 | Invalid-operation status pulse |
| den_o | output | 1 | Denormal-operand status pulse |

## Verification
The bench builds the block as a 6-bit format with a 3-bit exponent and a 2-bit fraction. At that size every operand pair can be run in both modes: zeros of both signs, subnormals, normals, infinities, and quiet and signalling NaNs of both signs. The expected result comes from the integer value the bench computes for each encoding. The mask bits change from pair to pair, so the flag-hold rule is tested with every combination of exceptions.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

    typedef enum logic [1:0] {
        ORD_GT = 2'd0,
        ORD_LT = 2'd1,
        ORD_EQ = 2'd2,
        ORD_UN = 2'd3
    } ord_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_sub;
        logic is_zero;
    } cls_t;

    localparam int FLAG_W   = 6;
    localparam int FL_CARRY = 0;
    localparam int FL_PAR   = 1;
    localparam int FL_ZERO  = 2;
    localparam int FL_AUX   = 3;
    localparam int FL_SIGN  = 4;
    localparam int FL_OVF   = 5;

    // Result code onto {zero, parity, carry}.
    function automatic logic [2:0] ord_code(ord_e r);
        case (r)
            ORD_GT:  return 3'b000;
            ORD_LT:  return 3'b001;
            ORD_EQ:  return 3'b100;
            default: return 3'b111;
        endcase
    endfunction

    function automatic logic [FLAG_W-1:0] flag_word(ord_e r);
        logic [FLAG_W-1:0] f;
        f = '0;
        {f[FL_ZERO], f[FL_PAR], f[FL_CARRY]} = ord_code(r);
        return f;
    endfunction

endpackage

// File: rtl/cmpf_classify.sv
module cmpf_classify
    import cmpf_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] op_i,
    output cls_t         cls_o
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_ones;
    logic             exp_zero;
    logic             man_zero;

    always_comb begin
        exp_f    = op_i[W-2 -: EXP_W];
        man_f    = op_i[MAN_W-1:0];
        exp_ones = &exp_f;
        exp_zero = ~|exp_f;
        man_zero = ~|man_f;
        cls_o.is_nan  = exp_ones & ~man_zero;
        cls_o.is_snan = exp_ones & ~man_zero & ~man_f[MAN_W-1];
        cls_o.is_sub  = exp_zero & ~man_zero;
        cls_o.is_zero = exp_zero & man_zero;
    end
endmodule

// File: rtl/cmpf_order.sv
module cmpf_order
    import cmpf_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  cls_t         cls_a_i,
    input  cls_t         cls_b_i,
    output ord_e         ord_o
);
    logic [W-2:0] mag_a;
    logic [W-2:0] mag_b;
    logic         sa;
    logic         sb;
    logic         mag_gt;
    logic         mag_eq;

    always_comb begin
        mag_a  = a_i[W-2:0];
        mag_b  = b_i[W-2:0];
        sa     = a_i[W-1];
        sb     = b_i[W-1];
        mag_gt = mag_a > mag_b;
        mag_eq = mag_a == mag_b;
        if (cls_a_i.is_nan || cls_b_i.is_nan)
            ord_o = ORD_UN;
        else if (cls_a_i.is_zero && cls_b_i.is_zero)
            ord_o = ORD_EQ;
        else if (sa != sb)
            ord_o = sa ? ORD_LT : ORD_GT;
        else if (mag_eq)
            ord_o = ORD_EQ;
        else if (mag_gt ^ sa)
            ord_o = ORD_GT;
        else
            ord_o = ORD_LT;
    end
endmodule

// File: rtl/cmpf_flagreg.sv
module cmpf_flagreg
    import cmpf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  ord_e              ord_i,
    input  logic              inv_i,
    input  logic              den_i,
    input  logic              inv_mask_i,
    input  logic              den_mask_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              inv_o,
    output logic              den_o
);
    logic fault;
    logic wr_en;

    always_comb begin
        fault = (inv_i & ~inv_mask_i) | (den_i & ~den_mask_i);
        wr_en = valid_i & ~fault;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_o <= '0;
            inv_o   <= 1'b0;
            den_o   <= 1'b0;
        end else begin
            inv_o <= valid_i & inv_i;
            den_o <= valid_i & den_i;
            if (wr_en)
                flags_o <= flag_word(ord_i);
        end
    end
endmodule

// File: rtl/cmpf_flag_unit.sv
module cmpf_flag_unit
    import cmpf_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [W-1:0]      op_a_i,
    input  logic [W-1:0]      op_b_i,
    input  logic              sig_mode_i,
    input  logic              inv_mask_i,
    input  logic              den_mask_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              inv_o,
    output logic              den_o
);
    logic [W-1:0] ops [2];
    cls_t         cls [2];
    ord_e         ord;
    logic         inv_raw;
    logic         den_raw;

    assign ops[0] = op_a_i;
    assign ops[1] = op_b_i;

    for (genvar i = 0; i < 2; i++) begin : g_cls
        cmpf_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .op_i  (ops[i]),
            .cls_o (cls[i])
        );
    end

    cmpf_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_ord (
        .a_i     (op_a_i),
        .b_i     (op_b_i),
        .cls_a_i (cls[0]),
        .cls_b_i (cls[1]),
        .ord_o   (ord)
    );

    always_comb begin
        if (sig_mode_i)
            inv_raw = cls[0].is_nan | cls[1].is_nan;
        else
            inv_raw = cls[0].is_snan | cls[1].is_snan;
        den_raw = cls[0].is_sub | cls[1].is_sub;
    end

    cmpf_flagreg u_reg (
        .clk        (clk),
        .rst        (rst),
        .valid_i    (valid_i),
        .ord_i      (ord),
        .inv_i      (inv_raw),
        .den_i      (den_raw),
        .inv_mask_i (inv_mask_i),
        .den_mask_i (den_mask_i),
        .flags_o    (flags_o),
        .inv_o      (inv_o),
        .den_o      (den_o)
    );
endmodule

// File: rtl/cmpf_flag_unit_chk.sv
module cmpf_flag_unit_chk #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input logic         clk,
    input logic         rst,
    input logic         valid_i,
    input logic [W-1:0] op_a_i,
    input logic [W-1:0] op_b_i,
    input logic         sig_mode_i,
    input logic         inv_mask_i,
    input logic         den_mask_i,
    input logic [5:0]   flags_o,
    input logic         inv_o,
    input logic         den_o
);
    logic a_snan;
    logic b_snan;
    assign a_snan = (&op_a_i[W-2 -: EXP_W]) && (|op_a_i[MAN_W-1:0]) && !op_a_i[MAN_W-1];
    assign b_snan = (&op_b_i[W-2 -: EXP_W]) && (|op_b_i[MAN_W-1:0]) && !op_b_i[MAN_W-1];

    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        flags_o[2:0] == 3'b000 || flags_o[2:0] == 3'b001 ||
        flags_o[2:0] == 3'b100 || flags_o[2:0] == 3'b111 ||
        flags_o == 6'b0);

    // R3
    upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(flags_o[5:3]) == 0);

    // R6
    quiet_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_o && !$past(sig_mode_i)) |-> ($past(a_snan) || $past(b_snan)));

    // R8
    inv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_o && !$past(inv_mask_i)) |-> $stable(flags_o));

    // R8
    den_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (den_o && !$past(den_mask_i)) |-> $stable(flags_o));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(valid_i) |-> (!inv_o && !den_o && $stable(flags_o)));
endmodule

bind cmpf_flag_unit cmpf_flag_unit_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (valid_i),
    .op_a_i     (op_a_i),
    .op_b_i     (op_b_i),
    .sig_mode_i (sig_mode_i),
    .inv_mask_i (inv_mask_i),
    .den_mask_i (den_mask_i),
    .flags_o    (flags_o),
    .inv_o      (inv_o),
    .den_o      (den_o)
);

// File: tb/sim_cmpf_flag_unit.sv
module sim_cmpf_flag_unit;
    localparam int EW = 3;
    localparam int MW = 2;
    localparam int W  = 1 + EW + MW;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid_i = 1'b0;
    logic [W-1:0] op_a_i = '0;
    logic [W-1:0] op_b_i = '0;
    logic         sig_mode_i = 1'b0;
    logic         inv_mask_i = 1'b0;
    logic         den_mask_i = 1'b0;
    logic [5:0]   flags_o;
    logic         inv_o;
    logic         den_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cmpf_flag_unit #(.EXP_W(EW), .MAN_W(MW)) u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
        .sig_mode_i(sig_mode_i), .inv_mask_i(inv_mask_i), .den_mask_i(den_mask_i),
        .flags_o(flags_o), .inv_o(inv_o), .den_o(den_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_nan(input int v);
        return ((v >> MW) & 7) == 7 && (v & 3) != 0;
    endfunction
    function automatic bit is_snan(input int v);
        return is_nan(v) && ((v >> 1) & 1) == 0;
    endfunction
    function automatic bit is_sub(input int v);
        return ((v >> MW) & 7) == 0 && (v & 3) != 0;
    endfunction
    // Exact value scaled by 2^(MW) * 2^(bias-1); infinity maps past every finite value.
    function automatic int value(input int v);
        int e, m, mag;
        e = (v >> MW) & 7;
        m = v & 3;
        if (e == 7)      mag = 1000;
        else if (e == 0) mag = m;
        else             mag = (4 + m) << (e - 1);
        return ((v >> (W - 1)) & 1) ? -mag : mag;
    endfunction

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int exp_flags;
        exp_flags = 0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 flags", int'(flags_o), 0);
        chk("R11 inv", int'(inv_o), 0);
        chk("R11 den", int'(den_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 flags after release", int'(flags_o), 0);

        for (int md = 0; md < 2; md++) begin
            for (int a = 0; a < 64; a++) begin
                for (int b = 0; b < 64; b++) begin
                    int va, vb, code, e_inv, e_den, fault;
                    string tag;
                    op_a_i     = W'(a);
                    op_b_i     = W'(b);
                    sig_mode_i = md[0];
                    inv_mask_i = a[1] ^ b[0];
                    den_mask_i = a[0] ^ b[1];
                    valid_i    = 1'b1;
                    va = value(a);
                    vb = value(b);
                    if (is_nan(a) || is_nan(b)) begin code = 7; tag = "R2 unordered"; end
                    else if (va > vb)            begin code = 0; tag = "R1 greater"; end
                    else if (va < vb)            begin code = 1; tag = "R1 less"; end
                    else                         begin code = 4; tag = "R1 equal"; end
                    if ((a & 31) == 0 && (b & 31) == 0) tag = "R4 signed zero";
                    else if ((is_sub(a) || is_sub(b)) && code != 7) tag = "R10 subnormal";
                    e_inv = md ? (is_nan(a) || is_nan(b)) : (is_snan(a) || is_snan(b));
                    e_den = is_sub(a) || is_sub(b);
                    fault = (e_inv && !inv_mask_i) || (e_den && !den_mask_i);
                    if (!fault) exp_flags = code;
                    @(negedge clk);
                    valid_i = 1'b0;
                    if (fault) chk("R8 hold", int'(flags_o), exp_flags);
                    else       chk(tag, int'(flags_o[2:0]), code);
                    chk("R3 upper zero", int'(flags_o[5:3]), 0);
                    chk(md ? "R5 invalid" : "R6 invalid", int'(inv_o), e_inv);
                    chk("R7 denormal", int'(den_o), e_den);
                    @(negedge clk);
                    chk("R9 idle pulses", int'({inv_o, den_o}), 0);
                    chk("R9 idle flags", int'(flags_o), exp_flags);
                end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule